// File: doc/BRIEF.md
# Saturating Carry-Chain Scan Unit

This unit forms a running sum over a vector whose elements are spread across an ordered row of virtual lanes. The lane being served takes a carry from its predecessor and adds its own element to it. The sum is then limited to a programmable floor and ceiling. The limited value is emitted as that lane's result and also becomes the next lane's carry. Lanes are served strictly in index order, so a strip of results is exactly a sequential saturating scan.

The carry that leaves the final lane of a strip is written back into a small carry queue. The first lane of the following strip draws its carry from that queue, which lets a long vector be processed as a series of strips while the running sum continues across strip boundaries. A control port can push a starting carry into the queue before the first strip, usually zero. The same port can pop a carry out, for example to read the final total.

Top module: `sat_scan_chain`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, the carry queue is empty (`q_empty`=1, `q_full`=0), and the next lane expected is lane 0.
- R2: An element is accepted (`in_ready`=1) only when `in_lane` equals the expected lane. The expected lane runs 0, 1, … up to `cfg_vlen`−1 and then returns to 0. An element with any other lane index is not accepted and produces no output.
- R3: A lane's result is computed as follows. Add carry and element as signed 16-bit values without wrap. If the sum is below `cfg_min`, replace it by `cfg_min`. Then, if the value is above `cfg_max`, replace it by `cfg_max`. When `cfg_min` > `cfg_max`, the result is therefore `cfg_max`.
- R4: One cycle after an element is accepted, `out_valid` is 1, with the result on `out_data` and the lane index on `out_lane`. That result is the carry used by the next lane.
- R5: The result of lane `cfg_vlen`−1 is pushed into the carry queue, and lane 0 removes the queue head as its carry.
- R6: Lane 0 is not accepted while the carry queue is empty.
- R7: When `ctl_pop_req` is 1 and the queue is not empty, `ctl_pop_ack` is 1, `ctl_pop_data` shows the queue head, and that entry is removed. When lane 0 is accepted in the same cycle, lane 0 has priority and `ctl_pop_ack` stays 0.
- R8: The carry queue holds 2 entries in first-in first-out order. `ctl_push_ready` is 0 while the queue is full or while the last lane is writing into it. A refused push leaves the queue contents unchanged.
- R9: The last lane is stalled while the queue is full. The exception is a vector length of 1, where lane 0 frees an entry in the same cycle, and the element is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_min | input | 16 | Signed lower clamp bound |
| cfg_max | input | 16 | Signed upper clamp bound |
| cfg_vlen | input | 4 | Vector length, 1 to NLANES |
| in_valid | input | 1 | Element offered |
| in_ready | output | 1 | Element accepted this cycle when valid |
| in_lane | input | 3 | Lane index of the offered element |
| in_data | input | 16 | Signed element value |
| out_valid | output | 1 | Result valid |
| out_lane | output | 3 | Lane index of the result |
| out_data | output | 16 | Signed clamped result |
| ctl_push_valid | input | 1 | Control push request into carry queue |
| ctl_push_ready | output | 1 | Control push accepted |
| ctl_push_data | input | 16 | Carry value to push |
| ctl_pop_req | input | 1 | Control pop request |
| ctl_pop_ack | output | 1 | Control pop performed this cycle |
| ctl_pop_data | output | 16 | Queue head value |
| q_full | output | 1 | Carry queue full |
| q_empty | output | 1 | Carry queue empty |

## Verification
The bench targets several corner cases, each tied to a specific wrong design:
- A sum that overflows 16 bits: a design that adds in 16 bits would wrap to a negative number instead of saturating at the ceiling.
- An inverted range: a design that clamps in the other order would return the floor instead of the ceiling.
- Lane 0 and a control pop contending for the same queue entry: a design without priority would hand one carry to both.
- A control push into a full queue: a design without back-pressure would overwrite or drop an entry.
- A vector length of one with a full queue: a design missing the same-cycle pop-and-push path would deadlock.

// File: rtl/sat_scan_pkg.sv
package sat_scan_pkg;

    localparam int DW = 16;

    typedef logic signed [DW-1:0] val_t;
    typedef logic signed [DW:0]   wide_t;

    typedef struct packed {
        val_t result;
        logic floor_hit;
        logic ceil_hit;
    } step_t;

    // Floor applied first, ceiling second: an inverted range yields the ceiling.
    function automatic step_t clamp_step(val_t carry, val_t elem, val_t lo, val_t hi);
        step_t r;
        wide_t s;
        s = wide_t'(carry) + wide_t'(elem);
        r.floor_hit = 1'b0;
        r.ceil_hit  = 1'b0;
        if (s < wide_t'(lo)) begin
            s = wide_t'(lo);
            r.floor_hit = 1'b1;
        end
        if (s > wide_t'(hi)) begin
            s = wide_t'(hi);
            r.ceil_hit = 1'b1;
        end
        r.result = val_t'(s);
        return r;
    endfunction

endpackage

// File: rtl/lane_step.sv
module lane_step
    import sat_scan_pkg::*;
(
    input  val_t  carry_in,
    input  val_t  elem,
    input  val_t  lo,
    input  val_t  hi,
    output step_t step
);
    always_comb begin
        step = clamp_step(carry_in, elem, lo, hi);
    end
endmodule

// File: rtl/carry_fifo.sv
module carry_fifo
    import sat_scan_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  val_t push_data,
    input  logic pop,
    output val_t head,
    output logic full,
    output logic empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    val_t          mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop)); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty); // R7
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R8
endmodule

// File: rtl/sat_scan_chain.sv
module sat_scan_chain
    import sat_scan_pkg::*;
#(
    parameter int NLANES = 8,
    parameter int QDEPTH = 2,
    localparam int LANE_W = $clog2(NLANES),
    localparam int VL_W   = $clog2(NLANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] cfg_min,
    input  logic signed [DW-1:0] cfg_max,
    input  logic [VL_W-1:0]      cfg_vlen,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [LANE_W-1:0]    in_lane,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    output logic [LANE_W-1:0]    out_lane,
    output logic signed [DW-1:0] out_data,
    input  logic                 ctl_push_valid,
    output logic                 ctl_push_ready,
    input  logic signed [DW-1:0] ctl_push_data,
    input  logic                 ctl_pop_req,
    output logic                 ctl_pop_ack,
    output logic signed [DW-1:0] ctl_pop_data,
    output logic                 q_full,
    output logic                 q_empty
);
    logic [LANE_W-1:0] cur_lane;
    val_t              carry_r;
    val_t              q_head, q_wdata, carry_in;
    logic              is_first, is_last, carry_ok, room_ok, accept;
    logic              q_push, q_pop, chain_pop, chain_push;
    step_t             step;

    assign is_first = (cur_lane == '0);
    assign is_last  = (VL_W'(cur_lane) == cfg_vlen - VL_W'(1));
    assign carry_in = is_first ? q_head : carry_r;
    assign carry_ok = !is_first || !q_empty;
    assign room_ok  = !is_last || !q_full || is_first;
    assign in_ready = (in_lane == cur_lane) && carry_ok && room_ok;
    assign accept   = in_valid && in_ready;

    assign chain_pop      = accept && is_first;
    assign chain_push     = accept && is_last;
    assign ctl_pop_ack    = ctl_pop_req && !q_empty && !chain_pop;
    assign ctl_push_ready = !q_full && !chain_push;
    assign ctl_pop_data   = q_head;

    assign q_pop   = chain_pop || ctl_pop_ack;
    assign q_push  = chain_push || (ctl_push_valid && ctl_push_ready);
    assign q_wdata = chain_push ? step.result : ctl_push_data;

    lane_step u_step (
        .carry_in (carry_in),
        .elem     (in_data),
        .lo       (cfg_min),
        .hi       (cfg_max),
        .step     (step)
    );

    carry_fifo #(.DEPTH(QDEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .push_data (q_wdata),
        .pop       (q_pop),
        .head      (q_head),
        .full      (q_full),
        .empty     (q_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_lane  <= '0;
            carry_r   <= '0;
            out_valid <= 1'b0;
            out_lane  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                carry_r  <= step.result;
                out_data <= step.result;
                out_lane <= cur_lane;
                cur_lane <= is_last ? '0 : cur_lane + LANE_W'(1);
            end
        end
    end

    AST_LANE0_HAS_CARRY: assert property (@(posedge clk) disable iff (rst)
        (accept && in_lane == '0) |-> !q_empty); // R6
    AST_WRAP_TO_LANE0: assert property (@(posedge clk) disable iff (rst)
        (accept && is_last) |=> (cur_lane == '0)); // R2
    AST_OUT_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $stable(cfg_min) && $stable(cfg_max) && cfg_min <= cfg_max)
        |-> (out_data >= cfg_min && out_data <= cfg_max)); // R3
    AST_POP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (accept && is_first) |-> !ctl_pop_ack); // R7
    AST_OUT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid); // R4
endmodule

// File: tb/test_sat_scan_chain.sv
module test_sat_scan_chain;
    localparam int CLK_P = 10;
    localparam int TBL [16] = '{30, 40, 50, -20, -120, -10, 5, 90,
                                60, 70, -300, -5, 100, 1, -1, -99};

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [15:0] cfg_min = -16'sd100, cfg_max = 16'sd100;
    logic [3:0]         cfg_vlen = 4'd4;
    logic               in_valid = 1'b0, in_ready;
    logic [2:0]         in_lane = '0;
    logic signed [15:0] in_data = '0;
    logic               out_valid;
    logic [2:0]         out_lane;
    logic signed [15:0] out_data;
    logic               ctl_push_valid = 1'b0, ctl_push_ready;
    logic signed [15:0] ctl_push_data = '0;
    logic               ctl_pop_req = 1'b0, ctl_pop_ack;
    logic signed [15:0] ctl_pop_data;
    logic               q_full, q_empty;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    sat_scan_chain i_sat_scan_chain (
        .clk, .rst, .cfg_min, .cfg_max, .cfg_vlen,
        .in_valid, .in_ready, .in_lane, .in_data,
        .out_valid, .out_lane, .out_data,
        .ctl_push_valid, .ctl_push_ready, .ctl_push_data,
        .ctl_pop_req, .ctl_pop_ack, .ctl_pop_data,
        .q_full, .q_empty
    );

    function automatic int model(int c, int e, int lo, int hi);
        int s;
        s = c + e;
        if (s < lo) s = lo;
        if (s > hi) s = hi;
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int v);
        ctl_push_valid = 1'b1;
        ctl_push_data  = 16'(v);
        #1;
        while (!ctl_push_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        ctl_push_valid = 1'b0;
    endtask

    task automatic pop(input int exp, input string tag);
        ctl_pop_req = 1'b1;
        #1;
        chk(ctl_pop_ack == 1'b1, {tag, " pop ack"}, int'(ctl_pop_ack), 1);
        chk(int'(ctl_pop_data) == exp, {tag, " pop data"}, int'(ctl_pop_data), exp);
        @(posedge clk);
        @(negedge clk);
        ctl_pop_req = 1'b0;
    endtask

    task automatic send(input int lane, input int v, input int exp, input string tag);
        in_valid = 1'b1;
        in_lane  = 3'(lane);
        in_data  = 16'(v);
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, {tag, " out_valid"}, int'(out_valid), 1);
        chk(int'(out_data) == exp, {tag, " out_data"}, int'(out_data), exp);
        chk(int'(out_lane) == lane, {tag, " out_lane"}, int'(out_lane), lane);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int carry;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state, R6 lane 0 stalls on empty queue
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(q_empty == 1'b1, "R1 q_empty", int'(q_empty), 1);
        chk(q_full == 1'b0, "R1 q_full", int'(q_full), 0);
        chk(in_ready == 1'b0, "R6 stall empty", int'(in_ready), 0);
        @(negedge clk);

        push(0);
        chk(q_empty == 1'b0, "R8 q_empty after push", int'(q_empty), 0);

        // R2 wrong lane index refused
        in_valid = 1'b1;
        in_lane  = 3'd2;
        in_data  = 16'sd7;
        #1;
        chk(in_ready == 1'b0, "R2 lane mismatch", int'(in_ready), 0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R2 no output", int'(out_valid), 0);

        // Table walk: R3 R4 R5 strips with carry across the queue
        carry = 0;
        for (int i = 0; i < 16; i++) begin
            carry = model(carry, TBL[i], -100, 100);
            send(i % 4, TBL[i], carry, "R3 table");
        end
        pop(carry, "R5 final carry");
        chk(q_empty == 1'b1, "R7 empty after pop", int'(q_empty), 1);

        // R3 inverted range gives max
        cfg_min  = 16'sd50;
        cfg_max  = 16'sd10;
        cfg_vlen = 4'd2;
        push(0);
        send(0, 3, 10, "R3 inverted");
        send(1, -40, 10, "R3 inverted");
        pop(10, "R5 inverted wrap");

        // R3 sum beyond 16 bits saturates
        cfg_min = -16'sd32768;
        cfg_max = 16'sd32767;
        push(30000);
        send(0, 30000, 32767, "R3 wide sum");
        send(1, -32768, -1, "R3 wide sum");
        pop(-1, "R5 wide wrap");

        // R7 lane 0 beats control pop, vector length 1
        cfg_min  = -16'sd100;
        cfg_max  = 16'sd100;
        cfg_vlen = 4'd1;
        push(5);
        ctl_pop_req = 1'b1;
        in_valid    = 1'b1;
        in_lane     = 3'd0;
        in_data     = 16'sd3;
        #1;
        chk(ctl_pop_ack == 1'b0, "R7 lane0 priority", int'(ctl_pop_ack), 0);
        chk(in_ready == 1'b1, "R7 lane0 accepted", int'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        ctl_pop_req = 1'b0;
        in_valid    = 1'b0;
        chk(int'(out_data) == 8, "R4 vlen1 result", int'(out_data), 8);
        pop(8, "R5 vlen1 wrap");

        // R8 full queue refuses push, R9 vlen1 pass-through when full
        push(7);
        push(9);
        chk(q_full == 1'b1, "R8 q_full", int'(q_full), 1);
        ctl_push_valid = 1'b1;
        ctl_push_data  = 16'sd11;
        #1;
        chk(ctl_push_ready == 1'b0, "R8 push refused", int'(ctl_push_ready), 0);
        @(posedge clk);
        @(negedge clk);
        ctl_push_valid = 1'b0;
        send(0, 1, 8, "R9 full vlen1");
        chk(q_full == 1'b1, "R9 still full", int'(q_full), 1);
        pop(9, "R8 order first");
        pop(8, "R8 order second");
        chk(q_empty == 1'b1, "R8 nothing extra", int'(q_empty), 1);

        finish_run();
    end
endmodule